// File: doc/BRIEF.md
# Banked Register File with Control Registers and Event Shadows

This block keeps the architectural register state of a small 32-bit integer processor. It holds two banks of sixteen general-purpose registers. One bit of the processor status word picks which bank serves every operand access. Both read ports are combinational, and the single write port updates the selected bank on the rising clock edge. Register 0 is an ordinary register. It is not tied to zero.

A separate space of thirteen control registers is reached only through a control index, with a read path and a write path. It holds the status word, the vector base (driven out for the vector fetch logic), two saved-status/saved-PC pairs, five scratch words, a global control word and a global status word. When an exception strobe arrives, the current status word and program counter are copied into the exception pair. A fast interrupt strobe copies them into its own pair instead. When both strobes fire together, the fast interrupt wins. An access to a control index above the implemented range reads zero, changes nothing, and raises a one-cycle illegal-index flag.

Top module: `cpu_reg_state`

## Requirements
- R1: After reset, every register in both banks and every control register is zero, so `psr_out`, `vbr_out` and `cr_bad` are all zero.
- R2: With `wr_en` high, `wr_data` lands in register `wr_idx` of the selected bank at the next rising edge. Both read ports show the selected bank combinationally. Register 0 stores data like any other register.
- R3: Status bit 1 selects the bank, 1 for the alternate bank and 0 for the normal one. Reads and writes touch only the selected bank, and the other bank keeps its contents.
- R4: Control index encoding: 0 status, 1 vector base, 2 exception-saved status, 3 fast-saved status, 4 exception-saved PC, 5 fast-saved PC, 6 to 10 scratch, 11 global control, 12 global status. With `cr_wr_en` high, `cr_wr_data` is written at the edge. `cr_rd_data` shows the indexed register combinationally. `psr_out` mirrors index 0 and `vbr_out` mirrors index 1.
- R5: On `exc_req` alone, index 2 takes the status word and index 4 takes `pc_in`, both as they stood before the edge.
- R6: On `fiq_req`, index 3 takes the status word and index 5 takes `pc_in`, and indices 2 and 4 are unchanged.
- R7: When `exc_req` and `fiq_req` are high in the same cycle, only the fast pair is captured. The exception pair keeps its old values.
- R8: A capture and a control write to the same saved register in the same cycle leave the captured value. A control write to the status word in the capture cycle does not alter the value saved.
- R9: A control index from 13 to 31 reads as zero and its writes are dropped. If either `cr_rd_en` or `cr_wr_en` was high with such an index, `cr_bad` is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | General register write index |
| wr_data | input | 32 | General register write data |
| cr_idx | input | 5 | Control register index |
| cr_rd_en | input | 1 | Control register read (move-from) strobe |
| cr_wr_en | input | 1 | Control register write (move-to) strobe |
| cr_wr_data | input | 32 | Control register write data |
| cr_rd_data | output | 32 | Control register read data |
| pc_in | input | 32 | Current program counter |
| exc_req | input | 1 | Exception event strobe |
| fiq_req | input | 1 | Fast interrupt event strobe |
| psr_out | output | 32 | Current status word |
| vbr_out | output | 32 | Vector table base |
| cr_bad | output | 1 | One-cycle illegal control index flag |

## Verification
Two things can land in the same cycle: the exception capture and the fast interrupt capture. The bench forces this collision on purpose, with distinct status and PC values. It then reads all four saved registers back through the control read path and confirms that only the fast pair moved. It also pairs each capture with a control write aimed at the same saved register, and with a status write. The reference model applies the capture last and takes the status value from before the edge, so a design that favours the software write or the new status word shows up as a mismatch.

// File: rtl/cpu_regs_pkg.sv
package cpu_regs_pkg;
  localparam int unsigned NUM_CR = 13;
  localparam int unsigned CRI_W  = 5;
  localparam int unsigned SEL_BIT = 1;

  localparam int unsigned IDX_STAT  = 0;
  localparam int unsigned IDX_VBASE = 1;
  localparam int unsigned IDX_XSTAT = 2;
  localparam int unsigned IDX_FSTAT = 3;
  localparam int unsigned IDX_XPC   = 4;
  localparam int unsigned IDX_FPC   = 5;
  localparam int unsigned IDX_SCR0  = 6;
  localparam int unsigned IDX_GCTL  = 11;
  localparam int unsigned IDX_GSTAT = 12;

  function automatic logic cr_idx_legal(input logic [CRI_W-1:0] idx);
    return idx < CRI_W'(NUM_CR);
  endfunction

  function automatic logic cr_hit(input logic [CRI_W-1:0] idx, input int unsigned slot);
    return idx == CRI_W'(slot);
  endfunction
endpackage

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NREGS = 16,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   ra,
  input  logic [AW-1:0]   rb,
  output logic [XLEN-1:0] rda,
  output logic [XLEN-1:0] rdb
);
  logic [XLEN-1:0] regs_q [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NREGS); i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign rda = regs_q[ra];
  assign rdb = regs_q[rb];
endmodule

// File: rtl/event_arb.sv
module event_arb (
  input  logic exc_req,
  input  logic fiq_req,
  output logic take_exc,
  output logic take_fiq
);
  assign take_fiq = fiq_req;
  assign take_exc = exc_req && !fiq_req;
endmodule

// File: rtl/ctrl_space.sv
module ctrl_space
  import cpu_regs_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CRI_W-1:0] cr_idx,
  input  logic             cr_rd_en,
  input  logic             cr_wr_en,
  input  logic [XLEN-1:0]  cr_wr_data,
  input  logic [XLEN-1:0]  pc_in,
  input  logic             take_exc,
  input  logic             take_fiq,
  output logic [XLEN-1:0]  cr_rd_data,
  output logic [XLEN-1:0]  psr,
  output logic [XLEN-1:0]  vbr,
  output logic [XLEN-1:0]  epsr,
  output logic [XLEN-1:0]  epc,
  output logic [XLEN-1:0]  fpsr,
  output logic [XLEN-1:0]  fpc,
  output logic             bad
);
  logic [XLEN-1:0] cr_v [NUM_CR];
  logic            bad_q;

  for (genvar s = 0; s < int'(NUM_CR); s++) begin : g_cr
    logic [XLEN-1:0] q;
    logic [XLEN-1:0] nxt;
    logic            upd;
    always_comb begin
      upd = cr_wr_en && cr_hit(cr_idx, s);
      nxt = cr_wr_data;
      if (s == int'(IDX_XSTAT) && take_exc) begin upd = 1'b1; nxt = cr_v[IDX_STAT]; end
      if (s == int'(IDX_XPC)   && take_exc) begin upd = 1'b1; nxt = pc_in; end
      if (s == int'(IDX_FSTAT) && take_fiq) begin upd = 1'b1; nxt = cr_v[IDX_STAT]; end
      if (s == int'(IDX_FPC)   && take_fiq) begin upd = 1'b1; nxt = pc_in; end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (upd) q <= nxt;
    end
    assign cr_v[s] = q;
  end

  always_comb begin
    cr_rd_data = '0;
    for (int i = 0; i < int'(NUM_CR); i++)
      if (cr_hit(cr_idx, i)) cr_rd_data = cr_v[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= (cr_rd_en || cr_wr_en) && !cr_idx_legal(cr_idx);
  end

  assign bad  = bad_q;
  assign psr  = cr_v[IDX_STAT];
  assign vbr  = cr_v[IDX_VBASE];
  assign epsr = cr_v[IDX_XSTAT];
  assign epc  = cr_v[IDX_XPC];
  assign fpsr = cr_v[IDX_FSTAT];
  assign fpc  = cr_v[IDX_FPC];
endmodule

// File: rtl/cpu_reg_state.sv
module cpu_reg_state
  import cpu_regs_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NGPR  = 16,
  localparam int unsigned GW   = $clog2(NGPR),
  localparam int unsigned NBANK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GW-1:0]    rd_a_idx,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic [GW-1:0]    rd_b_idx,
  output logic [XLEN-1:0]  rd_b_data,
  input  logic             wr_en,
  input  logic [GW-1:0]    wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [CRI_W-1:0] cr_idx,
  input  logic             cr_rd_en,
  input  logic             cr_wr_en,
  input  logic [XLEN-1:0]  cr_wr_data,
  output logic [XLEN-1:0]  cr_rd_data,
  input  logic [XLEN-1:0]  pc_in,
  input  logic             exc_req,
  input  logic             fiq_req,
  output logic [XLEN-1:0]  psr_out,
  output logic [XLEN-1:0]  vbr_out,
  output logic             cr_bad
);
  logic            exc_take, fiq_take;
  logic [XLEN-1:0] epsr_w, epc_w, fpsr_w, fpc_w;
  logic            bank_sel;
  logic [XLEN-1:0] bank_rda [NBANK];
  logic [XLEN-1:0] bank_rdb [NBANK];

  event_arb u_arb (
    .exc_req (exc_req),
    .fiq_req (fiq_req),
    .take_exc(exc_take),
    .take_fiq(fiq_take)
  );

  ctrl_space #(.XLEN(XLEN)) u_cr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cr_idx    (cr_idx),
    .cr_rd_en  (cr_rd_en),
    .cr_wr_en  (cr_wr_en),
    .cr_wr_data(cr_wr_data),
    .pc_in     (pc_in),
    .take_exc  (exc_take),
    .take_fiq  (fiq_take),
    .cr_rd_data(cr_rd_data),
    .psr       (psr_out),
    .vbr       (vbr_out),
    .epsr      (epsr_w),
    .epc       (epc_w),
    .fpsr      (fpsr_w),
    .fpc       (fpc_w),
    .bad       (cr_bad)
  );

  assign bank_sel = psr_out[SEL_BIT];

  for (genvar b = 0; b < int'(NBANK); b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (bank_sel == b[0]);
    gpr_bank #(.XLEN(XLEN), .NREGS(NGPR)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (bank_we),
      .waddr(wr_idx),
      .wdata(wr_data),
      .ra   (rd_a_idx),
      .rb   (rd_b_idx),
      .rda  (bank_rda[b]),
      .rdb  (bank_rdb[b])
    );
  end

  assign rd_a_data = bank_rda[bank_sel];
  assign rd_b_data = bank_rdb[bank_sel];
endmodule

// File: rtl/cpu_reg_state_chk.sv
module cpu_reg_state_chk
  import cpu_regs_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CRI_W-1:0] cr_idx,
  input logic             cr_rd_en,
  input logic             cr_wr_en,
  input logic [XLEN-1:0]  cr_wr_data,
  input logic [XLEN-1:0]  cr_rd_data,
  input logic             cr_bad,
  input logic [XLEN-1:0]  pc_in,
  input logic             exc_take,
  input logic             fiq_take,
  input logic [XLEN-1:0]  psr_out,
  input logic [XLEN-1:0]  vbr_out,
  input logic [XLEN-1:0]  epsr_w,
  input logic [XLEN-1:0]  epc_w,
  input logic [XLEN-1:0]  fpsr_w,
  input logic [XLEN-1:0]  fpc_w
);
  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_take, fiq_take})); // R7

  AST_EXC_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (epsr_w == $past(psr_out)) && (epc_w == $past(pc_in))); // R5

  AST_FIQ_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_take |=> (fpsr_w == $past(psr_out)) && (fpc_w == $past(pc_in))); // R6

  AST_FIQ_KEEPS_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_take && !(cr_wr_en && (cr_hit(cr_idx, IDX_XSTAT) || cr_hit(cr_idx, IDX_XPC))))
    |=> $stable(epsr_w) && $stable(epc_w)); // R6

  AST_BAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cr_rd_en || cr_wr_en) && !cr_idx_legal(cr_idx)) |=> cr_bad); // R9

  AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !((cr_rd_en || cr_wr_en) && !cr_idx_legal(cr_idx)) |=> !cr_bad); // R9

  AST_BAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cr_idx_legal(cr_idx) |-> (cr_rd_data == '0)); // R9

  AST_VBASE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr_en && cr_hit(cr_idx, IDX_VBASE)) |=> (vbr_out == $past(cr_wr_data))); // R4
endmodule

bind cpu_reg_state cpu_reg_state_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cr_idx    (cr_idx),
  .cr_rd_en  (cr_rd_en),
  .cr_wr_en  (cr_wr_en),
  .cr_wr_data(cr_wr_data),
  .cr_rd_data(cr_rd_data),
  .cr_bad    (cr_bad),
  .pc_in     (pc_in),
  .exc_take  (exc_take),
  .fiq_take  (fiq_take),
  .psr_out   (psr_out),
  .vbr_out   (vbr_out),
  .epsr_w    (epsr_w),
  .epc_w     (epc_w),
  .fpsr_w    (fpsr_w),
  .fpc_w     (fpc_w)
);

// File: tb/cpu_reg_state_tb.sv
module cpu_reg_state_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  cr_idx = '0;
  logic        cr_rd_en = 1'b0, cr_wr_en = 1'b0;
  logic [31:0] cr_wr_data = '0, cr_rd_data, pc_in = '0;
  logic        exc_req = 1'b0, fiq_req = 1'b0;
  logic [31:0] psr_out, vbr_out;
  logic        cr_bad;

  always #4 clk = ~clk;

  cpu_reg_state u_dut (.*);

  int    n_cmp = 0, n_bad = 0;
  string req = "R1";
  logic [31:0] m_gpr [2][16];
  logic [31:0] m_cr  [13];
  logic        m_bad;
  bit          done = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int sel();
    return int'(m_cr[0][1]);
  endfunction

  task automatic compare_all();
    chk("read A", rd_a_data, m_gpr[sel()][rd_a_idx]);
    chk("read B", rd_b_data, m_gpr[sel()][rd_b_idx]);
    chk("ctl read", cr_rd_data, (cr_idx < 13) ? m_cr[cr_idx] : 32'h0);
    chk("status", psr_out, m_cr[0]);
    chk("vbase", vbr_out, m_cr[1]);
    chk("bad flag", {31'h0, cr_bad}, {31'h0, m_bad});
  endtask

  task automatic model_step();
    logic [31:0] old_stat = m_cr[0];
    int b = sel();
    if (wr_en) m_gpr[b][wr_idx] = wr_data;
    m_bad = (cr_rd_en || cr_wr_en) && (cr_idx >= 13);
    if (cr_wr_en && cr_idx < 13) m_cr[cr_idx] = cr_wr_data;
    if (fiq_req) begin m_cr[3] = old_stat; m_cr[5] = pc_in; end
    else if (exc_req) begin m_cr[2] = old_stat; m_cr[4] = pc_in; end
  endtask

  task automatic cyc();
    #1 compare_all();
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    wr_en = 0; cr_wr_en = 0; cr_rd_en = 0; exc_req = 0; fiq_req = 0;
  endtask

  task automatic ctl_wr(int idx, logic [31:0] v);
    cr_idx = 5'(idx); cr_wr_en = 1; cr_wr_data = v; cyc();
  endtask

  task automatic sweep_reads();
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); cr_idx = 5'(i % 13); cyc();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int i = 0; i < 16; i++) m_gpr[b][i] = '0;
    for (int i = 0; i < 13; i++) m_cr[i] = '0;
    m_bad = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    req = "R1"; sweep_reads();

    req = "R2";
    for (int i = 0; i < 16; i++) begin
      wr_en = 1; wr_idx = 4'(i); wr_data = 32'hA000_0000 + 32'(i * 17);
      rd_a_idx = 4'(i); rd_b_idx = 4'(i); cyc();
    end
    sweep_reads();

    req = "R3";
    ctl_wr(0, 32'h0000_0002);
    sweep_reads();
    for (int i = 0; i < 16; i++) begin
      wr_en = 1; wr_idx = 4'(i); wr_data = 32'hB500_0000 + 32'(i); cyc();
    end
    sweep_reads();
    ctl_wr(0, 32'h0000_0001);
    sweep_reads();
    ctl_wr(0, 32'h0000_0002);
    wr_en = 1; wr_idx = 0; wr_data = 32'hDEAD_0000; cyc();
    sweep_reads();

    req = "R4";
    for (int i = 1; i < 13; i++) ctl_wr(i, 32'h1234_0000 ^ 32'(i * 32'h0101));
    ctl_wr(0, 32'hF0F0_0000);
    for (int i = 0; i < 13; i++) begin cr_idx = 5'(i); cr_rd_en = 1; cyc(); end

    req = "R5";
    pc_in = 32'h0000_4440; exc_req = 1; cyc();
    sweep_reads();
    req = "R6";
    ctl_wr(0, 32'h0000_0C03);
    pc_in = 32'h0000_7770; fiq_req = 1; cyc();
    sweep_reads();
    req = "R7";
    ctl_wr(0, 32'h0000_0055);
    pc_in = 32'h0000_9990; exc_req = 1; fiq_req = 1; cyc();
    for (int i = 2; i < 6; i++) begin cr_idx = 5'(i); cyc(); end
    req = "R8";
    pc_in = 32'h0000_AAA0; exc_req = 1; cr_idx = 2; cr_wr_en = 1; cr_wr_data = 32'h5555_5555; cyc();
    pc_in = 32'h0000_BBB0; fiq_req = 1; cr_idx = 0; cr_wr_en = 1; cr_wr_data = 32'h0000_0300; cyc();
    pc_in = 32'h0000_CCC0; fiq_req = 1; cr_idx = 5; cr_wr_en = 1; cr_wr_data = 32'h6666_6666; cyc();
    for (int i = 0; i < 6; i++) begin cr_idx = 5'(i); cyc(); end

    req = "R9";
    for (int i = 13; i < 32; i++) begin
      cr_idx = 5'(i); cr_wr_en = 1; cr_wr_data = 32'hFFFF_FFFF; cyc();
      cr_idx = 5'(i); cr_rd_en = (i % 2 == 0); cyc();
      cyc();
    end
    for (int i = 0; i < 13; i++) begin cr_idx = 5'(i); cyc(); end

    req = "mixed R2 R3 R5 R6 R7 R9";
    for (int n = 0; n < 400; n++) begin
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      wr_en = 1'($urandom); wr_idx = 4'($urandom); wr_data = $urandom;
      cr_idx = 5'($urandom); cr_rd_en = 1'($urandom); cr_wr_en = ($urandom % 4 == 0);
      cr_wr_data = $urandom; pc_in = $urandom;
      exc_req = ($urandom % 5 == 0); fiq_req = ($urandom % 6 == 0);
      cyc();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule